// File: doc/BRIEF.md
# Bounded-Quotient Fixed-Point Divider

This block divides an unsigned integer operand by an unsigned 16-bit divisor and returns a quotient with 10 fractional bits. The operand is widened by placing ten zero bits beneath it, and the result is the floor of that scaled value over the divisor. The system around the block keeps the two operands in a ratio where the true quotient is always below 2^18. Because of that bound, the divider resolves only the 18 quotient bits that can be non-zero, one per clock. It does not walk through every bit position of the 44-bit scaled operand.

A single-cycle start strobe captures both operands. A shared adder/subtractor then runs a non-restoring recurrence for 18 clocks. A partial remainder is kept in signed form. Each step either takes away or adds back the divisor, depending on the remainder's sign, and the sign of the new remainder gives the next quotient bit, most significant first. A one-cycle done strobe marks the arrival of a new quotient on the output register. The quotient then holds until the next completion. No remainder is returned. A zero divisor completes on the same schedule and yields an all-ones quotient.

Top module: `fxdiv_bounded`

## Requirements
- R1: While reset is asserted and after it is released with no start, done_o is 0 and quot_o is 0.
- R2: For any operand pair whose true quotient is below 2^18, the quotient delivered with done_o equals floor((value_i * 1024) / divisor_i).
- R3: When start_i is sampled high on a clock edge and no further start follows, done_o is high for exactly one cycle after the 18th following edge, and low after every edge in between.
- R4: quot_o changes only on the edge that raises done_o and otherwise holds its value, including while a division is in progress.
- R5: A zero divisor produces quot_o = 0x3FFFF, with done_o raised on the same 18-cycle schedule as any other division.
- R6: A start_i sampled while a division is in progress abandons that division. No done_o is issued for it, and done_o follows 18 edges after the latest start with the latest operands' quotient.
- R7: Boundary results are exact: a zero quotient, the largest quotient 0x3FFFF, divisor 1 and divisor 0xFFFF all give the floor value of R2.
- R8: value_i and divisor_i are sampled only on the start edge. Changing them while a division runs has no effect on the delivered quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that captures the operands and begins a division |
| value_i | input | 34 | Unsigned operand, scaled internally by 2^10 |
| divisor_i | input | 16 | Unsigned divisor |
| done_o | output | 1 | One-cycle strobe: a new quotient is on quot_o |
| quot_o | output | 18 | Quotient with 8 integer and 10 fractional bits |

## Verification
The embedded properties check the timing skeleton on every cycle. They confirm that done is a single-cycle pulse, that a start reloads the step counter and suppresses a pending done, and that a final step always produces done one edge later. They also confirm that the output register moves only after a final step, that a zero divisor lands on all ones, and that the partial remainder stays within plus or minus the divisor for every step of an in-range division. The bench scenarios are needed to show that the quotient values are correct: the floor result for random in-range pairs and for the extreme quotients and divisors, the insensitivity to operand changes during a run, and the result that a restart leaves behind.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;

  localparam int unsigned VAL_W_DEF  = 34;
  localparam int unsigned DIV_W_DEF  = 16;
  localparam int unsigned FRAC_W_DEF = 10;
  localparam int unsigned Q_W_DEF    = 18;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fxdiv_state_e;

endpackage

// File: rtl/fxdiv_ctrl.sv
module fxdiv_ctrl
  import fxdiv_pkg::*;
#(
  parameter int unsigned Q_W = Q_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic step_o,
  output logic last_o,
  output logic done_o
);

  localparam int unsigned CW = $clog2(Q_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(Q_W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  fxdiv_state_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          done_q, done_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (start_i) begin
      st_n  = ST_RUN;
      cnt_n = CNT_FULL;
    end else if (st_q == ST_RUN) begin
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_ONE) begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
    end
  end

  assign cnt_en = start_i | (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign step_o = (st_q == ST_RUN) & ~start_i;
  assign last_o = step_o & (cnt_q == CNT_ONE);
  assign done_o = done_q;

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_load_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (st_q == ST_RUN) && (cnt_q == CNT_FULL));

  p_finish_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && !start_i && (cnt_q == CNT_ONE)) |=> done_q);

  p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_q);

  p_run_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (cnt_q != '0) && (cnt_q <= CNT_FULL));

endmodule

// File: rtl/fxdiv_step.sv
module fxdiv_step #(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned R_W  = DIV_W + 2
) (
  input  logic [R_W-1:0]   rem_i,
  input  logic             bit_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [R_W-1:0]   rem_o,
  output logic             qbit_o
);

  logic [R_W-1:0] shifted;
  logic [R_W-1:0] div_ext;

  always_comb begin
    shifted = {rem_i[R_W-2:0], bit_i};
    div_ext = {2'b00, div_i};
    if (rem_i[R_W-1]) rem_o = shifted + div_ext;
    else              rem_o = shifted - div_ext;
    qbit_o = ~rem_o[R_W-1];
  end

endmodule

// File: rtl/fxdiv_dpath.sv
module fxdiv_dpath
  import fxdiv_pkg::*;
#(
  parameter int unsigned VAL_W  = VAL_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned Q_W    = Q_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic [Q_W-1:0]   quot_o
);

  localparam int unsigned SD_W = VAL_W + FRAC_W;
  localparam int unsigned HI_W = SD_W - Q_W;
  localparam int unsigned R_W  = DIV_W + 2;

  logic [SD_W-1:0]  scaled;
  logic [HI_W-1:0]  scaled_hi;
  logic [R_W-1:0]   rem_q, rem_n, rem_step;
  logic [Q_W-1:0]   work_q, work_n;
  logic [DIV_W-1:0] div_q;
  logic             dz_q;
  logic             qbit;
  logic [Q_W-1:0]   quot_q, quot_n;
  logic             work_en;

  assign scaled    = {value_i, {FRAC_W{1'b0}}};
  assign scaled_hi = scaled[SD_W-1:Q_W];

  fxdiv_step #(.DIV_W(DIV_W)) u_step (
    .rem_i  (rem_q),
    .bit_i  (work_q[Q_W-1]),
    .div_i  (div_q),
    .rem_o  (rem_step),
    .qbit_o (qbit)
  );

  always_comb begin
    rem_n  = rem_q;
    work_n = work_q;
    if (load_i) begin
      rem_n  = R_W'(scaled_hi);
      work_n = scaled[Q_W-1:0];
    end else if (step_i) begin
      rem_n  = rem_step;
      work_n = {work_q[Q_W-2:0], qbit};
    end
    quot_n = dz_q ? {Q_W{1'b1}} : {work_q[Q_W-2:0], qbit};
  end

  assign work_en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      work_q <= '0;
      div_q  <= '0;
      dz_q   <= 1'b0;
      quot_q <= '0;
    end else begin
      if (work_en) begin
        rem_q  <= rem_n;
        work_q <= work_n;
      end
      if (load_i) begin
        div_q <= divisor_i;
        dz_q  <= (divisor_i == '0);
      end
      if (last_i) quot_q <= quot_n;
    end
  end

  assign quot_o = quot_q;

  logic signed [R_W-1:0] div_s;
  assign div_s = $signed({2'b00, div_q});

  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !dz_q) |-> ($signed(rem_q) < div_s) && ($signed(rem_q) >= -div_s));

  p_quot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last_i) |-> $stable(quot_q));

  p_zero_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && dz_q) |=> (quot_q == {Q_W{1'b1}}));

endmodule

// File: rtl/fxdiv_bounded.sv
module fxdiv_bounded
  import fxdiv_pkg::*;
#(
  parameter int unsigned VAL_W  = VAL_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned Q_W    = Q_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quot_o
);

  logic step;
  logic last;

  fxdiv_ctrl #(.Q_W(Q_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done_o)
  );

  fxdiv_dpath #(
    .VAL_W  (VAL_W),
    .DIV_W  (DIV_W),
    .FRAC_W (FRAC_W),
    .Q_W    (Q_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start_i),
    .step_i    (step),
    .last_i    (last),
    .value_i   (value_i),
    .divisor_i (divisor_i),
    .quot_o    (quot_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !done_o);

endmodule

// File: tb/sim_fxdiv_bounded.sv
module sim_fxdiv_bounded;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LAT        = 18;
  localparam int unsigned WD_LIMIT   = 100000;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [33:0] value_i;
  logic [15:0] divisor_i;
  logic        done_o;
  logic [17:0] quot_o;

  int checks;
  int failures;
  int cycles;
  bit finished;

  fxdiv_bounded u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .value_i   (value_i),
    .divisor_i (divisor_i),
    .done_o    (done_o),
    .quot_o    (quot_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] ref_quot(input logic [33:0] v, input logic [15:0] d);
    logic [43:0] n;
    if (d == 16'd0) return 18'h3FFFF;
    n = {v, 10'b0};
    return 18'(n / {28'b0, d});
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Runs one division; operands are scrambled while it runs (R8).
  task automatic run_div(input logic [33:0] v, input logic [15:0] d, input string req);
    logic [17:0] exp;
    logic [17:0] prev;
    bit early;
    bit hold_ok;
    exp     = ref_quot(v, d);
    prev    = quot_o;
    early   = 1'b0;
    hold_ok = 1'b1;
    @(negedge clk);
    start_i   = 1'b1;
    value_i   = v;
    divisor_i = d;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < LAT; i++) begin
      if (done_o) early = 1'b1;
      if (quot_o !== prev) hold_ok = 1'b0;
      value_i   = {2'b0, $urandom()};
      divisor_i = 16'($urandom());
      @(negedge clk);
    end
    check(!early, "R3", "done before 18th edge", 64'(early), 64'd0);
    check(hold_ok, "R4", "quot moved during run", 64'(quot_o), 64'(prev));
    check(done_o === 1'b1, "R3", "done at 18th edge", 64'(done_o), 64'd1);
    check(quot_o === exp, req, "quotient", 64'(quot_o), 64'(exp));
    @(negedge clk);
    check(done_o === 1'b0, "R3", "done single cycle", 64'(done_o), 64'd0);
    check(quot_o === exp, "R4", "quot held after done", 64'(quot_o), 64'(exp));
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        checks++;
        failures++;
        $display("FAIL watchdog cycles=%0d expected<=%0d", cycles, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] span;
    logic [33:0] v;
    checks    = 0;
    failures  = 0;
    finished  = 1'b0;
    start_i   = 1'b0;
    value_i   = '0;
    divisor_i = '0;
    rst_n     = 1'b0;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(done_o === 1'b0, "R1", "done in reset", 64'(done_o), 64'd0);
    check(quot_o === 18'd0, "R1", "quot in reset", 64'(quot_o), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o === 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
    check(quot_o === 18'd0, "R1", "quot after reset", 64'(quot_o), 64'd0);

    // R7 boundary cases
    run_div(34'd0, 16'd1, "R7");
    run_div(34'd255, 16'd1, "R7");
    run_div(34'(32'hFFFF * 256 - 1), 16'hFFFF, "R7");
    run_div(34'd1, 16'hFFFF, "R7");
    run_div(34'd1000, 16'd1000, "R7");
    run_div(34'd4, 16'd1, "R7");
    // R5 zero divisor
    run_div(34'd12345, 16'd0, "R5");
    run_div(34'd0, 16'd0, "R5");

    // R6 restart while busy
    @(negedge clk);
    start_i   = 1'b1;
    value_i   = 34'd7777;
    divisor_i = 16'd33;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    run_div(34'd50000, 16'd397, "R6");

    // R2 random in-range pairs (quotient < 2^18 by construction)
    for (int k = 0; k < 200; k++) begin
      d    = 16'($urandom_range(1, 65535));
      span = {8'b0, d, 8'b0};
      v    = 34'($urandom() % span);
      run_div(v, d, "R2");
      if ((k % 37) == 5) repeat (2) @(negedge clk);
    end

    finish_run();
  end

endmodule